// File: doc/BRIEF.md
# Line Alarm Interrupt Controller

This block gathers four receive-path alarm levels from each of fourteen line channels and turns any change in those levels into a single active-low interrupt. Every alarm input is first brought into the local clock domain through a synchronizer. A rise or a fall of the synchronized level then sets a sticky change bit in that channel's status register. A per-alarm mask decides whether a latched change may contribute to its channel's pending flag. The fourteen channel flags are combined into one global flag. A global enable bit gates that flag onto the registered interrupt output.

Software reaches the block through a small register port with separate read and write strobes, a word address and read data that returns one cycle after the read strobe. A read-only global vector shows which channels are pending, so the handler can go straight to the channel that raised the interrupt. Reading a channel's status register returns its latched change bits and clears them. A separate read-only view shows the live alarm levels without touching any state.

Top module: `line_alarm_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1 and `irq_oe` is 0. The global enable reads 0, every channel mask reads 4'hF and every status reads 0. Alarm bit order within a channel is bit0 loss of signal, bit1 alarm indication signal, bit2 quasi-random pattern detect, bit3 flexible loss of signal. Channel c owns `alarm_in[4c+3:4c]`.
- R2: A rise or a fall on an alarm input sets the matching status bit. This happens whether or not the alarm is masked. With the enable set and the alarm unmasked, `irq_n` goes low on the fourth rising clock edge after the input changes.
- R3: A masked alarm never contributes to a channel's pending flag or to the interrupt. Mask register bit n is 1 to block alarm n.
- R4: While the global enable (bit 0 at address 0) is 0, `irq_n` is 1 from the edge after the enable register is written. Setting the enable again while a change is pending drives `irq_n` low on the following edge.
- R5: Reading a channel status register (address 4(c+1)) returns the latched change bits in bits [3:0] and clears them. `irq_n` returns high on the edge after the last pending status is read.
- R6: If a change arrives in the same cycle that its status bit is read, the read returns the old value and the bit stays set.
- R7: The register at address 1 reads a 14-bit vector in which bit c is 1 when channel c holds an unmasked latched change. This vector does not depend on the global enable.
- R8: The register at address 4(c+1)+2 returns channel c's current synchronized alarm levels. Reading it changes no state.
- R9: Read data and `rd_valid` appear on the edge after `rd_en`. Unmapped addresses read 0: address 2, address 3, offset 3 of each channel page, and pages above channel 13. Writes to read-only registers have no effect. Channel mask registers sit at address 4(c+1)+1.
- R10: `irq_oe` is always the complement of `irq_n`. The output is driven only while low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 56 | Asynchronous alarm levels, four per channel |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register word address |
| wdata | input | 16 | Register write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt |
| irq_oe | output | 1 | Output enable, high while the interrupt is asserted |

## Verification
An input change reaches the status bit on the third clock edge and `irq_n` on the fourth. The bench samples one negative edge before and one after that point, so an off-by-one in either direction is caught. Read data is due on the edge after the strobe, and the scoreboard monitor compares it at the following negative edge. A status read clears on that same edge, while `irq_n` releases one edge later. Enable writes likewise reach `irq_n` one edge after they land, and each such check looks at both sides of that edge. The same-cycle case is set up by placing the read strobe two negative edges after the input change, so the read lands exactly on the edge where the change bit is written.

// File: rtl/lai_pkg.sv
package lai_pkg;
  localparam int ALM_W = 4;
  localparam logic [1:0] FLD_STAT = 2'd0;
  localparam logic [1:0] FLD_MASK = 2'd1;
  localparam logic [1:0] FLD_LIVE = 2'd2;
  localparam logic [1:0] GLB_CTRL = 2'd0;
  localparam logic [1:0] GLB_PEND = 2'd1;
endpackage

// File: rtl/lai_sync_edge.sv
module lai_sync_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] st [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
      prev <= '0;
    end else begin
      st[0] <= din;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      prev <= st[STAGES-1];
    end
  end

  assign lvl = st[STAGES-1];
  assign chg = st[STAGES-1] ^ prev;
endmodule

// File: rtl/lai_chan_stat.sv
module lai_chan_stat #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] chg,
  input  logic         clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
    end else begin
      // a change in the clearing cycle survives the clear
      status <= (clr ? '0 : status) | chg;
      if (mask_we) mask <= mask_wd;
    end
  end

  assign flag = |(status & ~mask);

  assert_change_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|chg) |=> ((status & $past(chg)) == $past(chg)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && chg == '0) |=> (status == '0));

  assert_change_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && |chg) |=> (status == $past(chg)));
endmodule

// File: rtl/lai_irq_tree.sv
module lai_irq_tree #(
  parameter int NCH = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           glb_en,
  input  logic [NCH-1:0] chan_flag,
  output logic           irq_n,
  output logic           irq_oe
);
  logic any_pend;
  assign any_pend = |chan_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n  <= 1'b1;
      irq_oe <= 1'b0;
    end else begin
      irq_n  <= ~(glb_en & any_pend);
      irq_oe <= glb_en & any_pend;
    end
  end

  assert_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> irq_n);

  assert_fall_has_source_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(|chan_flag));
endmodule

// File: rtl/line_alarm_irq_ctrl.sv
module line_alarm_irq_ctrl
  import lai_pkg::*;
#(
  parameter int NUM_CH      = 14,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*ALM_W-1:0] alarm_in,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rdata,
  output logic                    irq_n,
  output logic                    irq_oe
);
  localparam int PAGE_W = ADDR_W - 2;

  logic [PAGE_W-1:0] page;
  logic [1:0]        fld;
  assign page = addr[ADDR_W-1:2];
  assign fld  = addr[1:0];

  logic              glb_en;
  logic [NUM_CH-1:0] chan_flag;
  logic [ALM_W-1:0]  status_a [NUM_CH];
  logic [ALM_W-1:0]  mask_a   [NUM_CH];
  logic [ALM_W-1:0]  live_a   [NUM_CH];

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) glb_en <= 1'b0;
    else if (wr_en && page == '0 && fld == GLB_CTRL) glb_en <= wdata[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(c + 1);
    logic             sel;
    logic [ALM_W-1:0] chg;
    assign sel = (page == MY_PAGE);

    lai_sync_edge #(.W(ALM_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (alarm_in[c*ALM_W +: ALM_W]),
      .lvl (live_a[c]),
      .chg (chg)
    );

    lai_chan_stat #(.W(ALM_W)) u_stat (
      .clk     (clk),
      .rst     (rst),
      .chg     (chg),
      .clr     (rd_en && sel && fld == FLD_STAT),
      .mask_we (wr_en && sel && fld == FLD_MASK),
      .mask_wd (wdata[ALM_W-1:0]),
      .status  (status_a[c]),
      .mask    (mask_a[c]),
      .flag    (chan_flag[c])
    );
  end

  lai_irq_tree #(.NCH(NUM_CH)) u_tree (
    .clk       (clk),
    .rst       (rst),
    .glb_en    (glb_en),
    .chan_flag (chan_flag),
    .irq_n     (irq_n),
    .irq_oe    (irq_oe)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (page == '0) begin
      if (fld == GLB_CTRL)      rd_mux[0] = glb_en;
      else if (fld == GLB_PEND) rd_mux[NUM_CH-1:0] = chan_flag;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (page == PAGE_W'(c + 1)) begin
          case (fld)
            FLD_STAT: rd_mux[ALM_W-1:0] = status_a[c];
            FLD_MASK: rd_mux[ALM_W-1:0] = mask_a[c];
            FLD_LIVE: rd_mux[ALM_W-1:0] = live_a[c];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  logic hole;
  assign hole = (page == '0 && fld[1]) ||
                (page > PAGE_W'(NUM_CH)) ||
                (page != '0 && fld == 2'd3);

  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hole) |=> (rd_valid && rdata == '0));

  assert_oe_tracks_R10: assert property (@(posedge clk) disable iff (rst)
    irq_oe != irq_n);
endmodule

// File: tb/line_alarm_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module line_alarm_irq_ctrl_tb_top;
  localparam int NCH = 14;
  localparam int AW  = 6;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH*4-1:0]  alarm_in = '0;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic              rd_valid;
  logic [DW-1:0]     rdata;
  logic              irq_n;
  logic              irq_oe;

  always #2.5 clk = ~clk;

  line_alarm_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .alarm_in(alarm_in), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  typedef struct { logic [DW-1:0] exp; string tag; } sb_item_t;
  sb_item_t sbq[$];
  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results come out
  always @(negedge clk) begin
    if (rd_valid) begin
      if (sbq.size() == 0) check(1'b0, "R9 unexpected rd_valid", 1, 0);
      else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(rdata == it.exp, it.tag, int'(rdata), int'(it.exp));
      end
    end
  end

  function automatic int a_stat(int c); return 4*(c+1);     endfunction
  function automatic int a_mask(int c); return 4*(c+1) + 1; endfunction
  function automatic int a_live(int c); return 4*(c+1) + 2; endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(int a, int d);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(int a, int e, string tag);
    sb_item_t it;
    it.exp = DW'(e); it.tag = tag;
    sbq.push_back(it);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_irq(bit exp_low, string tag);
    check(irq_n == !exp_low, {tag, " irq_n"}, int'(irq_n), int'(!exp_low));
    check(irq_oe == exp_low, {tag, " irq_oe R10"}, int'(irq_oe), int'(exp_low));
  endtask

  task automatic set_alarm(int c, int b, bit v);
    alarm_in[c*4 + b] = v;
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung actual=0x0 expected=0x1");
      report();
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check_irq(1'b0, "R1 reset");
    reg_rd(0, 0, "R1 enable after reset");
    reg_rd(a_mask(0), 'hF, "R1 mask after reset");
    reg_rd(a_stat(0), 0, "R1 status after reset");
    reg_rd(1, 0, "R1 pending after reset");
    reg_wr(a_mask(0), 0);
    reg_wr(a_mask(3), 0);
    // R4 disabled: change latched, no interrupt
    set_alarm(0, 0, 1'b1);
    tick(6);
    check_irq(1'b0, "R4 disabled");
    reg_rd(1, 1, "R7 pending independent of enable");
    reg_rd(a_stat(0), 1, "R2 status latched while disabled");
    tick(1);
    reg_wr(0, 1);
    tick(2);
    check_irq(1'b0, "R5 nothing pending");
    // R2 rising edge timing
    set_alarm(3, 1, 1'b1);
    tick(3);
    check_irq(1'b0, "R2 one edge early");
    tick(1);
    check_irq(1'b1, "R2 rise");
    reg_rd(1, 1 << 3, "R7 pending ch3");
    // R8 live view has no side effect
    reg_rd(a_live(3), 2, "R8 live ch3");
    reg_rd(a_live(0), 1, "R8 live ch0");
    check_irq(1'b1, "R8 live read keeps irq");
    // R5 read clear
    reg_rd(a_stat(3), 2, "R5 status ch3");
    check_irq(1'b1, "R5 release lag");
    tick(1);
    check_irq(1'b0, "R5 release");
    reg_rd(a_stat(3), 0, "R5 status cleared");
    // R2 falling edge
    set_alarm(3, 1, 1'b0);
    tick(4);
    check_irq(1'b1, "R2 fall");
    reg_rd(a_stat(3), 2, "R2 fall status");
    tick(1);
    check_irq(1'b0, "R5 fall cleared");
    // R3 masked channel 5
    set_alarm(5, 2, 1'b1);
    tick(6);
    check_irq(1'b0, "R3 masked");
    reg_rd(1, 0, "R3 pending masked");
    reg_rd(a_stat(5), 4, "R3 masked change latched");
    // R6 change coinciding with read clear
    set_alarm(3, 0, 1'b1);
    tick(2);
    reg_rd(a_stat(3), 0, "R6 read in change cycle");
    reg_rd(a_stat(3), 1, "R6 change kept");
    tick(1);
    check_irq(1'b0, "R6 released");
    // R9 holes and read-only writes
    reg_rd(3, 0, "R9 global hole");
    reg_rd(7, 0, "R9 channel hole");
    reg_rd(63, 0, "R9 beyond channels");
    reg_wr(1, 'hFFFF);
    reg_rd(1, 0, "R9 pending write ignored");
    reg_wr(a_live(3), 'hF);
    reg_rd(a_live(3), 1, "R9 live write ignored");
    // R7 two channels
    reg_wr(a_mask(13), 0);
    set_alarm(13, 3, 1'b1);
    set_alarm(3, 0, 1'b0);
    tick(4);
    check_irq(1'b1, "R7 two channels");
    reg_rd(1, (1 << 13) | (1 << 3), "R7 pending two channels");
    // R4 gate while pending
    reg_wr(0, 0);
    check_irq(1'b1, "R4 disable lag");
    tick(1);
    check_irq(1'b0, "R4 disable");
    reg_wr(0, 1);
    tick(1);
    check_irq(1'b1, "R4 re-enable");
    // R3 mask applied after latching
    reg_wr(a_mask(13), 'hF);
    reg_rd(1, 1 << 3, "R3 mask hides pending");
    reg_rd(a_stat(3), 1, "R5 ch3 drain");
    tick(2);
    check_irq(1'b0, "R3 masked ch13 alone");
    reg_rd(a_stat(13), 8, "R5 ch13 drain");
    tick(3);
    check(sbq.size() == 0, "R9 scoreboard drained", sbq.size(), 0);
    finished = 1;
    report();
    $finish;
  end
endmodule